// File: doc/BRIEF.md
# Luma Contrast and Brightness Stage

This block adjusts the contrast and brightness of an 8-bit luminance pixel stream. Pixels arrive with a valid strobe. Each incoming value has its nominal black level of 16 removed. The result is then scaled by a gain picked from a 6-bit contrast code. That gain covers zero up to just under two in 64 equal steps, and code 32 means exactly one. A signed 8-bit brightness offset is added after the scaling. The sum is then clamped to the 0..255 range and leaves the block two clock edges after it entered, with a valid flag that follows the data.

The contrast and brightness codes are not used straight from the pins. They are copied into working registers only on a clock edge at which neither pipeline stage holds a valid pixel. Because of this, one pixel is never processed with a mix of old and new settings. A control agent that changes the codes during a continuous run of pixels sees the change take effect only once the stream pauses and the pipeline drains.

Top module: `luma_cb_stage`

## Requirements
- R1: After reset, `pix_vld_o` is 0 and `pix_o` is 0.
- R2: `pix_vld_o` equals `pix_vld_i` as sampled two rising clock edges earlier; each valid input pixel yields exactly one valid output pixel.
- R3: With contrast code 32 and brightness 0, the output is the input minus 16, and inputs below 16 give 0.
- R4: The output before clamping is floor((pix − 16) × code / 32) + brightness. The floor rounds toward minus infinity, so a negative product rounds down.
- R5: Contrast code 0 removes the picture content: the output is the brightness value clamped to the range 0..255.
- R6: Brightness is an 8-bit two's-complement value from −128 to +127, added after the gain.
- R7: Any negative result after the brightness add is output as 0.
- R8: Any result above 255 is output as 255.
- R9: The contrast and brightness codes are loaded into the working settings only on a rising edge at which neither pipeline stage holds a valid pixel. A code change made while pixels are in flight, or while pixels keep arriving, affects no pixel until the pipeline has drained.
- R10: While `pix_vld_o` is 0, `pix_o` keeps the last value it presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously by the system |
| pix_vld_i | input | 1 | Input pixel valid strobe |
| pix_i | input | 8 | Input luminance, black at 16 |
| ctr_code_i | input | 6 | Contrast code, gain = code / 32 |
| brt_code_i | input | 8 | Brightness offset, two's complement |
| pix_vld_o | output | 1 | Output pixel valid, two edges after input |
| pix_o | output | 8 | Adjusted luminance, clamped to 0..255 |

## Verification
The assertions assume that reset is held across at least one rising edge, and that the control codes are ordinary binary values with no unknown bits whenever the pipeline is empty. Under those assumptions, the working settings registers must stay fixed while any stage is occupied. The stimulus drives every input at the falling edge and holds it steady across the rising edge. The stimulus changes the codes both while the pipeline is idle and in the middle of a continuous pixel run, so the load rule is exercised from both sides.

// File: rtl/luma_cb_pkg.sv
package luma_cb_pkg;
  parameter int PIX_W      = 8;
  parameter int CTR_W      = 6;
  parameter int BRT_W      = 8;
  parameter int BLACK_LVL  = 16;
  parameter int UNITY_LOG2 = 5;
endpackage

// File: rtl/luma_cb_settings.sv
module luma_cb_settings
  import luma_cb_pkg::*;
#(
  parameter int C_W = CTR_W,
  parameter int B_W = BRT_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           busy_i,
  input  logic [C_W-1:0] ctr_i,
  input  logic [B_W-1:0] brt_i,
  output logic [C_W-1:0] ctr_o,
  output logic [B_W-1:0] brt_o
);
  logic           load_en;
  logic [C_W-1:0] ctr_nxt;
  logic [B_W-1:0] brt_nxt;

  always_comb begin
    load_en = ~busy_i;
    ctr_nxt = ctr_o;
    brt_nxt = brt_o;
    if (load_en) begin
      ctr_nxt = ctr_i;
      brt_nxt = brt_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctr_o <= '0;
      brt_o <= '0;
    end else begin
      ctr_o <= ctr_nxt;
      brt_o <= brt_nxt;
    end
  end

  // R9: occupied pipeline freezes the working settings
  p_settings_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |=> ($stable(ctr_o) && $stable(brt_o)));
endmodule

// File: rtl/luma_cb_offset.sv
module luma_cb_offset
  import luma_cb_pkg::*;
#(
  parameter int P_W   = PIX_W,
  parameter int BLACK = BLACK_LVL
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                vld_i,
  input  logic [P_W-1:0]      pix_i,
  output logic                vld_o,
  output logic signed [P_W:0] dif_o
);
  localparam int D_W = P_W + 1;

  logic signed [D_W-1:0] dif_nxt;
  logic signed [D_W-1:0] dif_hold;

  always_comb begin
    dif_nxt  = $signed({1'b0, pix_i}) - $signed(D_W'(BLACK));
    dif_hold = vld_i ? dif_nxt : dif_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_o <= 1'b0;
      dif_o <= '0;
    end else begin
      vld_o <= vld_i;
      dif_o <= dif_hold;
    end
  end

  // R2 / R4: the stored difference always lies within [-BLACK, max - BLACK]
  p_dif_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    vld_i |=> (dif_o >= -$signed(D_W'(BLACK))));
endmodule

// File: rtl/luma_cb_gain.sv
module luma_cb_gain
  import luma_cb_pkg::*;
#(
  parameter int P_W   = PIX_W,
  parameter int C_W   = CTR_W,
  parameter int B_W   = BRT_W,
  parameter int SHIFT = UNITY_LOG2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                vld_i,
  input  logic signed [P_W:0] dif_i,
  input  logic [C_W-1:0]      ctr_i,
  input  logic [B_W-1:0]      brt_i,
  output logic                vld_o,
  output logic [P_W-1:0]      pix_o
);
  localparam int PROD_W  = P_W + C_W + 2;
  localparam int SUM_W   = PROD_W + 1;
  localparam int PIX_MAX = (1 << P_W) - 1;
  localparam int UNITY   = 1 << SHIFT;

  logic signed [C_W:0]      ctr_s;
  logic signed [B_W-1:0]    brt_s;
  logic signed [PROD_W-1:0] prod;
  logic signed [PROD_W-1:0] scaled;
  logic signed [SUM_W-1:0]  sum;
  logic [P_W-1:0]           clamped;
  logic [P_W-1:0]           pix_nxt;

  always_comb begin
    ctr_s  = $signed({1'b0, ctr_i});
    brt_s  = $signed(brt_i);
    prod   = PROD_W'(dif_i) * PROD_W'(ctr_s);
    scaled = prod >>> SHIFT;
    sum    = SUM_W'(scaled) + SUM_W'(brt_s);
    if (sum < 0)
      clamped = '0;
    else if (sum > $signed(SUM_W'(PIX_MAX)))
      clamped = P_W'(PIX_MAX);
    else
      clamped = sum[P_W-1:0];
    pix_nxt = vld_i ? clamped : pix_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_o <= 1'b0;
      pix_o <= '0;
    end else begin
      vld_o <= vld_i;
      pix_o <= pix_nxt;
    end
  end

  // R10: idle stage keeps its output
  p_hold_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_i |=> $stable(pix_o));

  // R5 / R7: zero gain with negative brightness yields black
  p_clip_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_i && ctr_i == '0 && brt_i[B_W-1]) |=> (pix_o == '0));

  // R3: unity gain, zero offset passes the difference through
  p_unity_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_i && ctr_i == C_W'(UNITY) && brt_i == '0 && !dif_i[P_W])
      |=> (pix_o == $past(dif_i[P_W-1:0])));
endmodule

// File: rtl/luma_cb_stage.sv
module luma_cb_stage
  import luma_cb_pkg::*;
#(
  parameter int P_W   = PIX_W,
  parameter int C_W   = CTR_W,
  parameter int B_W   = BRT_W,
  parameter int BLACK = BLACK_LVL,
  parameter int SHIFT = UNITY_LOG2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           pix_vld_i,
  input  logic [P_W-1:0] pix_i,
  input  logic [C_W-1:0] ctr_code_i,
  input  logic [B_W-1:0] brt_code_i,
  output logic           pix_vld_o,
  output logic [P_W-1:0] pix_o
);
  logic                vld_s1;
  logic signed [P_W:0] dif_s1;
  logic [C_W-1:0]      ctr_act;
  logic [B_W-1:0]      brt_act;
  logic                pipe_busy;

  always_comb pipe_busy = vld_s1 | pix_vld_o;

  luma_cb_settings #(.C_W(C_W), .B_W(B_W)) u_settings (
    .clk    (clk),
    .rst_n  (rst_n),
    .busy_i (pipe_busy),
    .ctr_i  (ctr_code_i),
    .brt_i  (brt_code_i),
    .ctr_o  (ctr_act),
    .brt_o  (brt_act)
  );

  luma_cb_offset #(.P_W(P_W), .BLACK(BLACK)) u_offset (
    .clk   (clk),
    .rst_n (rst_n),
    .vld_i (pix_vld_i),
    .pix_i (pix_i),
    .vld_o (vld_s1),
    .dif_o (dif_s1)
  );

  luma_cb_gain #(.P_W(P_W), .C_W(C_W), .B_W(B_W), .SHIFT(SHIFT)) u_gain (
    .clk   (clk),
    .rst_n (rst_n),
    .vld_i (vld_s1),
    .dif_i (dif_s1),
    .ctr_i (ctr_act),
    .brt_i (brt_act),
    .vld_o (pix_vld_o),
    .pix_o (pix_o)
  );

  // R2: valid emerges two edges after it entered
  p_latency_on_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pix_vld_i |=> ##1 pix_vld_o);
  p_latency_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_vld_i |=> ##1 !pix_vld_o);
endmodule

// File: tb/luma_cb_stage_bench.sv
`timescale 1ns/1ps
module luma_cb_stage_bench;
  logic       clk;
  logic       rst_n;
  logic       pix_vld_i;
  logic [7:0] pix_i;
  logic [5:0] ctr_code_i;
  logic [7:0] brt_code_i;
  logic       pix_vld_o;
  logic [7:0] pix_o;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  luma_cb_stage u_luma_cb_stage (
    .clk        (clk),
    .rst_n      (rst_n),
    .pix_vld_i  (pix_vld_i),
    .pix_i      (pix_i),
    .ctr_code_i (ctr_code_i),
    .brt_code_i (brt_code_i),
    .pix_vld_o  (pix_vld_o),
    .pix_o      (pix_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // behavioural reference: formula from R4, clamps from R7/R8
  function automatic int ref_pix(int p, int c, int b);
    int prod;
    int v;
    prod = (p - 16) * c;
    v = (prod >>> 5) + b;
    if (v < 0) v = 0;
    if (v > 255) v = 255;
    return v;
  endfunction

  int m_v1, m_p1, m_ctr, m_brt, m_ov, m_op;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_v1 = 0; m_p1 = 0; m_ctr = 0; m_brt = 0; m_ov = 0; m_op = 0;
    end else begin
      int busy;
      busy = m_v1 | m_ov;
      if (m_v1 != 0) m_op = ref_pix(m_p1, m_ctr, m_brt);
      m_ov = m_v1;
      if (busy == 0) begin
        m_ctr = int'(ctr_code_i);
        m_brt = int'($signed(brt_code_i));
      end
      m_v1 = int'(pix_vld_i);
      if (pix_vld_i) m_p1 = int'(pix_i);
    end
  end

  task automatic check(int act, int exp, string tag);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the reference (R2 valid, R4 data, R10 hold)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(int'(pix_vld_o), m_ov, "R2 valid vs model");
      check(int'(pix_o), m_op, "R4 R10 pixel vs model");
    end
  end

  task automatic one_pixel(int p, int c, int b, int exp, string tag);
    @(negedge clk);
    pix_i = 8'(p); ctr_code_i = 6'(c); brt_code_i = 8'(b); pix_vld_i = 1'b1;
    @(negedge clk);
    pix_vld_i = 1'b0;
    @(negedge clk);
    check(int'(pix_vld_o), 1, tag);
    check(int'(pix_o), exp, tag);
    repeat (2) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=expired expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : stim
    rst_n = 1'b0; pix_vld_i = 1'b0; pix_i = '0; ctr_code_i = 6'd32; brt_code_i = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(int'(pix_vld_o), 0, "R1 reset valid");
    check(int'(pix_o), 0, "R1 reset pixel");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    one_pixel(100, 32, 0, 84, "R3 unity pass");
    one_pixel(10, 32, 0, 0, "R3 below black");
    one_pixel(116, 48, 0, 150, "R4 gain 1.5");
    one_pixel(10, 33, 10, 3, "R4 floor negative");
    one_pixel(200, 0, 50, 50, "R5 zero gain");
    one_pixel(235, 32, -128, 91, "R6 negative brightness");
    one_pixel(16, 32, 127, 127, "R6 positive brightness");
    one_pixel(40, 32, -100, 0, "R7 clip low");
    one_pixel(200, 0, -1, 0, "R7 zero gain clip");
    one_pixel(255, 63, 0, 255, "R8 saturate");
    one_pixel(200, 32, 100, 255, "R8 saturate brightness");

    // R10: output holds while idle
    repeat (3) @(negedge clk);
    check(int'(pix_o), 255, "R10 hold idle");

    // R9: change settings mid-stream
    @(negedge clk);
    ctr_code_i = 6'd32; brt_code_i = 8'd0; pix_i = 8'd100; pix_vld_i = 1'b1;
    @(negedge clk);
    pix_i = 8'd110; ctr_code_i = 6'd16; brt_code_i = 8'd50;
    @(negedge clk);
    check(int'(pix_o), 84, "R9 first pixel old settings");
    pix_i = 8'd120;
    @(negedge clk);
    check(int'(pix_o), 94, "R9 in-flight keeps old settings");
    pix_i = 8'd130;
    @(negedge clk);
    check(int'(pix_o), 104, "R9 streaming keeps old settings");
    pix_vld_i = 1'b0;
    @(negedge clk);
    check(int'(pix_o), 114, "R9 last pixel old settings");
    repeat (2) @(negedge clk);
    one_pixel(100, 16, 50, 92, "R9 new settings after drain");

    // sweep, compared by the per-cycle model
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      pix_vld_i  = ((i % 5) != 3);
      pix_i      = 8'((i * 37 + 11) % 256);
      ctr_code_i = 6'((i / 7) % 64);
      brt_code_i = 8'((i * 13) % 256);
    end
    @(negedge clk);
    pix_vld_i = 1'b0;
    repeat (4) @(negedge clk);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule